// File: doc/BRIEF.md
# IDE Channel Host Register Front-End

This block is the memory-mapped front-end of a two-drive IDE channel. It occupies a 4 KB bus window and splits it into register slots 16 bytes apart. The slot number is bits 11:4 of the bus address. Each slot takes only the access sizes it supports. A data-port, task-file or status/command access that passes this check becomes a strobe on a device-side port. Behind that port sits the drive register logic, which is not part of this block.

Two registers are held locally. The first is a 32-bit drive timing word. The second is a 32-bit interrupt state word, which combines a DMA interrupt bit and a disk interrupt bit. The DMA bit stays set until software clears it. The disk bit follows the level of the disk interrupt. Each interrupt source is also passed straight to its own output line. A read of an undecoded slot returns all ones, and so does a read with a size the slot does not accept. All reads return their data one cycle after the request.

Top module: `ide_regfront`

## Requirements
- R1: The slot index is addr_i[11:4]. Registers therefore sit 16 bytes apart. A read of any slot other than 0x00..0x08, 0x16, 0x20 or 0x30 returns 0xFFFFFFFF.
- R2: Slot 0x00 is the data port. It accepts size_i of 2 or 4 bytes and drives dev_sel_o=0, with dev_wide_o=1 for 4-byte accesses. A 2-byte read returns the low 16 bits of dev_rdata_i, zero-extended. A 1-byte access reads 0xFFFFFFFF and raises no device strobe.
- R3: Slots 0x01..0x07 are task-file registers and accept only 1-byte accesses. They drive dev_sel_o=1, and dev_reg_o equals the slot number. A read returns dev_rdata_i[7:0], zero-extended. An access of any other size reads 0xFFFFFFFF and raises no strobe.
- R4: Slots 0x08 and 0x16 both map to the status/command register and accept only 1-byte accesses, with dev_sel_o=2. A read returns the drive status byte. A write issues a command write carrying wdata_i[7:0].
- R5: Slot 0x20 is a 32-bit timing register that is read and written only with 4-byte accesses. Writes of any other size leave it unchanged.
- R6: Slot 0x30 is the interrupt state register and is read only with 4-byte accesses. Bit 31 takes the new level of the DMA interrupt each time that level changes. Bit 30 follows the disk interrupt level one cycle later. All other bits read 0.
- R7: A 4-byte write to slot 0x30 with bit 31 set clears bit 31. Every other bit of that write is ignored. A change of the DMA level in the same cycle takes priority over the clear.
- R8: dma_irq_o follows dma_irq_i, and disk_irq_o follows disk_irq_i, with no delay.
- R9: Reset clears the timing and interrupt registers to 0. dev_rst_o is high during reset and for the first clock after it, and low from then on.
- R10: A read request produces dev_rd_o for exactly the request cycle. rdata_o and a one-cycle rvalid_o appear after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address inside the 4 KB window |
| size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| wdata_i | input | 32 | Write data, value in the low lanes (little-endian) |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| dev_rd_o | output | 1 | Device-side read strobe |
| dev_wr_o | output | 1 | Device-side write strobe |
| dev_sel_o | output | 2 | Device target: 0 data, 1 task file, 2 status/command |
| dev_reg_o | output | 3 | Task-file register number |
| dev_wide_o | output | 1 | Data-port access is 32 bits |
| dev_wdata_o | output | 32 | Device write data |
| dev_rdata_i | input | 32 | Device read data, valid in the strobe cycle |
| dev_rst_o | output | 1 | Channel reset pulse to the device |
| dma_irq_i | input | 1 | DMA interrupt source level |
| disk_irq_i | input | 1 | Disk interrupt source level |
| dma_irq_o | output | 1 | DMA interrupt line out |
| disk_irq_o | output | 1 | Disk interrupt line out |

## Verification
A wrong decode shows up within one access. A device strobe appears on a slot or size that should have been refused, or an all-ones read comes back from a valid register. A corrupted interrupt state shows up on the next 4-byte read of slot 0x30. A DMA bit that survives its clear write, or a disk bit that does not match the line level, is visible one cycle after the event that should have changed it. Timing register corruption appears on the first read-back after a rejected byte or halfword write.

// File: rtl/ide_regfront_pkg.sv
package ide_regfront_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int IW = AW - 4;

  typedef enum logic [2:0] {
    T_NONE, T_DATA, T_TASK, T_STCMD, T_TIMING, T_IRQ
  } target_e;

  localparam logic [IW-1:0] IDX_DATA   = 8'h00;
  localparam logic [IW-1:0] IDX_STAT_A = 8'h08;
  localparam logic [IW-1:0] IDX_STAT_B = 8'h16;
  localparam logic [IW-1:0] IDX_TIMING = 8'h20;
  localparam logic [IW-1:0] IDX_IRQ    = 8'h30;
  localparam int DMA_BIT  = 31;
  localparam int DISK_BIT = 30;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_regfront_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    size_i,
  output target_e       tgt_o,
  output logic [2:0]    reg_o
);
  logic [IW-1:0] idx;
  logic sz1, sz2, sz4;

  assign idx = addr_i[AW-1:4];
  assign sz1 = (size_i == 3'd1);
  assign sz2 = (size_i == 3'd2);
  assign sz4 = (size_i == 3'd4);
  assign reg_o = idx[2:0];

  always_comb begin
    tgt_o = T_NONE;
    if (idx == IDX_DATA) begin
      if (sz2 || sz4) tgt_o = T_DATA;
    end else if (idx < IW'(8)) begin
      if (sz1) tgt_o = T_TASK;
    end else if (idx == IDX_STAT_A || idx == IDX_STAT_B) begin
      if (sz1) tgt_o = T_STCMD;
    end else if (idx == IDX_TIMING) begin
      if (sz4) tgt_o = T_TIMING;
    end else if (idx == IDX_IRQ) begin
      if (sz4) tgt_o = T_IRQ;
    end
  end
endmodule

// File: rtl/ide_irq_state.sv
module ide_irq_state
  import ide_regfront_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_irq_i,
  input  logic          disk_irq_i,
  input  logic          clr_i,
  output logic [DW-1:0] state_o
);
  logic dma_prev, disk_prev, dma_bit, disk_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_prev  <= 1'b0;
      disk_prev <= 1'b0;
      dma_bit   <= 1'b0;
      disk_bit  <= 1'b0;
    end else begin
      dma_prev  <= dma_irq_i;
      disk_prev <= disk_irq_i;
      // source edge beats software clear so no event is lost
      if (dma_irq_i != dma_prev) dma_bit <= dma_irq_i;
      else if (clr_i)            dma_bit <= 1'b0;
      if (disk_irq_i != disk_prev) disk_bit <= disk_irq_i;
    end
  end

  always_comb begin
    state_o           = '0;
    state_o[DMA_BIT]  = dma_bit;
    state_o[DISK_BIT] = disk_bit;
  end

  assert_disk_mirror_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> state_o[DISK_BIT] == $past(disk_irq_i));
  assert_dma_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_irq_i) |=> state_o[DMA_BIT]);
  assert_dma_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && $stable(dma_irq_i)) |=> !state_o[DMA_BIT]);
endmodule

// File: rtl/ide_regfront.sv
module ide_regfront
  import ide_regfront_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [11:0]   addr_i,
  input  logic [2:0]    size_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          rvalid_o,
  output logic          dev_rd_o,
  output logic          dev_wr_o,
  output logic [1:0]    dev_sel_o,
  output logic [2:0]    dev_reg_o,
  output logic          dev_wide_o,
  output logic [31:0]   dev_wdata_o,
  input  logic [31:0]   dev_rdata_i,
  output logic          dev_rst_o,
  input  logic          dma_irq_i,
  input  logic          disk_irq_i,
  output logic          dma_irq_o,
  output logic          disk_irq_o
);
  target_e       tgt;
  logic [2:0]    reg_num;
  logic [DW-1:0] timing_q, irq_state, rd_mux;
  logic          dev_hit, irq_clr, timing_we, rst_done;

  ide_addr_decode u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .tgt_o  (tgt),
    .reg_o  (reg_num)
  );

  assign irq_clr = req_i && we_i && (tgt == T_IRQ) && wdata_i[DMA_BIT];

  ide_irq_state u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dma_irq_i  (dma_irq_i),
    .disk_irq_i (disk_irq_i),
    .clr_i      (irq_clr),
    .state_o    (irq_state)
  );

  assign dma_irq_o  = dma_irq_i;
  assign disk_irq_o = disk_irq_i;

  assign dev_hit     = req_i && (tgt == T_DATA || tgt == T_TASK || tgt == T_STCMD);
  assign dev_rd_o    = dev_hit && !we_i;
  assign dev_wr_o    = dev_hit && we_i;
  assign dev_sel_o   = (tgt == T_TASK) ? 2'd1 : (tgt == T_STCMD) ? 2'd2 : 2'd0;
  assign dev_reg_o   = (tgt == T_TASK) ? reg_num : 3'd0;
  assign dev_wide_o  = (tgt == T_DATA) && (size_i == 3'd4);
  assign dev_wdata_o = wdata_i;
  assign timing_we   = req_i && we_i && (tgt == T_TIMING);

  always_comb begin
    unique case (tgt)
      T_DATA:   rd_mux = dev_wide_o ? dev_rdata_i : {16'h0, dev_rdata_i[15:0]};
      T_TASK,
      T_STCMD:  rd_mux = {24'h0, dev_rdata_i[7:0]};
      T_TIMING: rd_mux = timing_q;
      T_IRQ:    rd_mux = irq_state;
      default:  rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      rst_done <= 1'b0;
    end else begin
      rst_done <= 1'b1;
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_mux;
      if (timing_we) timing_q <= wdata_i;
    end
  end

  assign dev_rst_o = !rst_done;

  assert_bad_size_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[11:4] == 8'h00 && size_i == 3'd1) |-> !(dev_rd_o || dev_wr_o));
  assert_rd_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rd_o |=> rvalid_o);
  assert_timing_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !timing_we |=> $stable(timing_q));
  assert_rst_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_rst_o |=> !dev_rst_o);
endmodule

// File: tb/ide_regfront_test.sv
module ide_regfront_test;
  logic clk_i = 0, rst_ni = 0;
  logic req_i = 0, we_i = 0;
  logic [11:0] addr_i = 0;
  logic [2:0] size_i = 0;
  logic [31:0] wdata_i = 0, rdata_o, dev_wdata_o, dev_rdata_i = 0;
  logic rvalid_o, dev_rd_o, dev_wr_o, dev_wide_o, dev_rst_o;
  logic [1:0] dev_sel_o;
  logic [2:0] dev_reg_o;
  logic dma_irq_i = 0, disk_irq_i = 0, dma_irq_o, disk_irq_o;
  int checks = 0, fails = 0;
  logic s_rd, s_wr, s_wide;
  logic [1:0] s_sel;
  logic [2:0] s_reg;
  logic [31:0] s_wd;

  always #5 clk_i = ~clk_i;

  ide_regfront uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a; size_i = sz;
    #1;
    s_rd = dev_rd_o; s_wr = dev_wr_o; s_sel = dev_sel_o; s_reg = dev_reg_o; s_wide = dev_wide_o;
    @(posedge clk_i); #1;
    req_i = 0;
    chk("R10 rvalid", {31'b0, rvalid_o}, 32'd1);
    d = rdata_o;
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] v);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; size_i = sz; wdata_i = v;
    #1;
    s_rd = dev_rd_o; s_wr = dev_wr_o; s_sel = dev_sel_o; s_reg = dev_reg_o; s_wd = dev_wdata_o;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R9 dev_rst in reset", {31'b0, dev_rst_o}, 32'd1);
    @(negedge clk_i); rst_ni = 1;
    chk("R9 dev_rst held until first edge", {31'b0, dev_rst_o}, 32'd1);
    @(posedge clk_i); #1;
    chk("R9 dev_rst dropped", {31'b0, dev_rst_o}, 32'd0);
    rd(12'h200, 3'd4, d); chk("R9 timing reset", d, 32'h0);
    rd(12'h300, 3'd4, d); chk("R9 irq reset", d, 32'h0);
    chk("R9 no repeat pulse", {31'b0, dev_rst_o}, 32'd0);
  endtask

  task automatic t_undecoded;
    logic [31:0] d;
    rd(12'h090, 3'd4, d); chk("R1 idx 9 undecoded", d, 32'hFFFF_FFFF);
    rd(12'hFF0, 3'd1, d); chk("R1 idx FF undecoded", d, 32'hFFFF_FFFF);
    rd(12'h100, 3'd1, d); chk("R1 idx 0x10 undecoded", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_data;
    logic [31:0] d;
    dev_rdata_i = 32'hA1B2_C3D4;
    rd(12'h004, 3'd4, d);
    chk("R2 word read", d, 32'hA1B2_C3D4);
    chk("R2 wide", {31'b0, s_wide}, 32'd1);
    chk("R10 rd strobe", {31'b0, s_rd}, 32'd1);
    @(negedge clk_i); chk("R10 strobe single cycle", {31'b0, dev_rd_o}, 32'd0);
    rd(12'h000, 3'd2, d);
    chk("R2 half read zext", d, 32'h0000_C3D4);
    chk("R2 sel data", {30'b0, s_sel}, 32'd0);
    rd(12'h000, 3'd1, d);
    chk("R2 byte read ones", d, 32'hFFFF_FFFF);
    chk("R2 byte no strobe", {31'b0, s_rd}, 32'd0);
    wr(12'h000, 3'd1, 32'h55);
    chk("R2 byte write dropped", {31'b0, s_wr}, 32'd0);
    wr(12'h000, 3'd2, 32'h1234);
    chk("R2 half write strobe", {31'b0, s_wr}, 32'd1);
    chk("R2 half write data", s_wd, 32'h1234);
  endtask

  task automatic t_task;
    logic [31:0] d;
    dev_rdata_i = 32'hFFFF_FF5A;
    for (int i = 1; i < 8; i++) begin
      rd(12'(i << 4), 3'd1, d);
      chk("R3 task read", d, 32'h5A);
      chk("R3 task reg num", {29'b0, s_reg}, 32'(i));
      chk("R3 task sel", {30'b0, s_sel}, 32'd1);
    end
    rd(12'h030, 3'd2, d);
    chk("R3 half on task ones", d, 32'hFFFF_FFFF);
    chk("R3 half no strobe", {31'b0, s_rd}, 32'd0);
  endtask

  task automatic t_stcmd;
    logic [31:0] d;
    dev_rdata_i = 32'h0000_0150;
    rd(12'h080, 3'd1, d);
    chk("R4 status via 0x08", d, 32'h50);
    chk("R4 sel 0x08", {30'b0, s_sel}, 32'd2);
    rd(12'h160, 3'd1, d);
    chk("R4 status via 0x16", d, 32'h50);
    chk("R4 sel 0x16", {30'b0, s_sel}, 32'd2);
    wr(12'h16C, 3'd1, 32'hEC);
    chk("R4 cmd write strobe", {31'b0, s_wr}, 32'd1);
    chk("R4 cmd write data", {24'b0, s_wd[7:0]}, 32'hEC);
    rd(12'h080, 3'd4, d);
    chk("R4 word on status ones", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    wr(12'h200, 3'd4, 32'hDEAD_BEEF);
    rd(12'h200, 3'd4, d); chk("R5 timing readback", d, 32'hDEAD_BEEF);
    wr(12'h200, 3'd1, 32'h0);
    wr(12'h200, 3'd2, 32'h0);
    rd(12'h200, 3'd4, d); chk("R5 narrow write ignored", d, 32'hDEAD_BEEF);
    rd(12'h200, 3'd2, d); chk("R5 narrow read ones", d, 32'hFFFF_FFFF);
    chk("R5 no device strobe", {31'b0, s_rd}, 32'd0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk_i); dma_irq_i = 1; disk_irq_i = 1; #1;
    chk("R8 dma line", {31'b0, dma_irq_o}, 32'd1);
    chk("R8 disk line", {31'b0, disk_irq_o}, 32'd1);
    rd(12'h300, 3'd4, d); chk("R6 both set", d, 32'hC000_0000);
    wr(12'h300, 3'd4, 32'h7FFF_FFFF);
    rd(12'h300, 3'd4, d); chk("R7 no bit31 no clear", d, 32'hC000_0000);
    wr(12'h300, 3'd4, 32'hFFFF_FFFF);
    rd(12'h300, 3'd4, d); chk("R7 clear only bit31", d, 32'h4000_0000);
    wr(12'h300, 3'd2, 32'h8000_0000);
    @(negedge clk_i); dma_irq_i = 0; disk_irq_i = 0; #1;
    chk("R8 dma line low", {31'b0, dma_irq_o}, 32'd0);
    chk("R8 disk line low", {31'b0, disk_irq_o}, 32'd0);
    rd(12'h300, 3'd4, d); chk("R6 both low", d, 32'h0);
    @(negedge clk_i); dma_irq_i = 1;
    rd(12'h300, 3'd4, d); chk("R6 dma relatch", d, 32'h8000_0000);
    @(negedge clk_i); dma_irq_i = 0; disk_irq_i = 1;
    rd(12'h300, 3'd4, d); chk("R6 dma follows fall, disk rise", d, 32'h4000_0000);
    // clear written in same cycle as DMA rise: rise wins
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 12'h300; size_i = 3'd4; wdata_i = 32'h8000_0000; dma_irq_i = 1;
    @(posedge clk_i); #1; req_i = 0; we_i = 0;
    rd(12'h300, 3'd4, d); chk("R7 rise beats clear", d, 32'hC000_0000);
    rd(12'h300, 3'd1, d); chk("R6 byte read ones", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk_i);
        t_reset();
        t_undecoded();
        t_data();
        t_task();
        t_stcmd();
        t_timing();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule